// File: doc/BRIEF.md
# Persist Fence and Commit Tracker

This block keeps, for every warp of a shader core, a count of memory requests that have been issued and not yet acknowledged. It uses those counts to carry out two ordering operations for persistent memory. A persist fence holds back its warp until every request that warp issued earlier has come back acknowledged. A commit first waits for the same condition. It then asks every memory controller at once to empty its write-pending queue, and it finishes only when each controller has reported its queue empty. The commit goes to all controllers because the stores of a single warp can be spread over any of them.

The instruction pipeline reads `warp_stall` and issues no memory operation for a warp whose bit is set. Commit requests that arrive while a commit is in progress wait their turn. Waiting commits are served from the lowest warp index upward. When the write-pending queues are declared durable through `durable_cfg`, a commit is unnecessary and completes at once, with no stall and no drain request.

Top module: `persist_order_tracker`

## Requirements
- R1: A fence from a warp whose outstanding count is zero never raises that warp's stall bit.
- R2: A fence from a warp with outstanding requests sets its `warp_stall` bit after the sampling edge. The bit stays set until the edge that samples the acknowledgement bringing the count to zero, and clears at that edge.
- R3: Fences and commits affect only the stall bit of the warp that issued them. Bit w of `warp_stall` belongs to warp w.
- R4: Each warp's outstanding count saturates at 2^CNT_W-1; further issues are lost. An acknowledgement for a warp whose count is zero is ignored.
- R5: A non-durable commit drives `drain_req` to all ones for exactly one cycle. It does this one edge after the edge at which the committing warp's count is zero and the commit is being served, and never before that warp's outstanding requests are acknowledged.
- R6: The committing warp stays stalled until every controller has pulsed its `drain_done` bit after the strobe, in any order and in any grouping. The stall clears at the edge that samples the last missing bit. Repeated pulses and pulses outside a commit change nothing.
- R7: A commit arriving while another is in progress stays stalled and receives its own strobe only after the first commit has completed.
- R8: With `durable_cfg` high, a commit neither stalls its warp nor produces a drain strobe.
- R9: After reset, all counts are zero, `warp_stall` is zero, `drain_req` is zero and no commit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| durable_cfg | input | 1 | Write-pending queues are durable; commits are no-ops |
| issue_vld | input | 1 | A memory request is issued |
| issue_warp | input | WARP_W | Warp of the issued request |
| ack_vld | input | 1 | A memory request is acknowledged |
| ack_warp | input | WARP_W | Warp of the acknowledged request |
| fence_req | input | 1 | Persist fence request |
| fence_warp | input | WARP_W | Warp issuing the fence |
| commit_req | input | 1 | Commit request |
| commit_warp | input | WARP_W | Warp issuing the commit |
| drain_done | input | NUM_CTRL | Per-controller queue-empty pulse |
| warp_stall | output | NUM_WARPS | Per-warp stall flag |
| drain_req | output | NUM_CTRL | Per-controller drain strobe |

## Verification
The bench aims at the count boundaries. An acknowledgement arriving at zero would wrap a naive counter and let a later fence pass too early. Issues beyond the saturation point would wrap the count and release a fence while requests are still outstanding. On the commit side, it checks that the strobe waits for the committing warp's last acknowledgement, that it lasts exactly one cycle, and that a commit holds until the last controller reports, even when some controllers report twice. A design that released early on a duplicate pulse, or on a pulse seen before the commit, would clear the stall too soon. It also queues a second commit behind a first, to catch a design that drops the later commit or serves it concurrently. Finally, it sets the durable configuration to catch a design that still stalls or strobes the controllers.

// File: rtl/pft_pkg.sv
package pft_pkg;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_FENCE = 2'd1,
        CM_DRAIN = 2'd2
    } commit_state_e;

    // index of the lowest set bit, 0 when none is set
    function automatic int unsigned first_set(input logic [63:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/warp_tracker.sv
module warp_tracker #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    input  logic fence_hit,
    output logic fence_stall,
    output logic cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic             fence_q, fence_next;

    always_comb begin
        cnt_next = cnt_q;
        case ({inc, dec})
            2'b10:   cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            2'b01:   cnt_next = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
            default: cnt_next = cnt_q;
        endcase
        fence_next = (fence_q | fence_hit) && (cnt_next != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fence_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_next;
            fence_q <= fence_next;
        end
    end

    assign fence_stall = fence_q;
    assign cnt_zero    = (cnt_q == '0);

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX)) else $error("count wrapped"); // R4
    AST_ZERO_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0)) else $error("count underflow"); // R4
    AST_FENCE_HELD: assert property (@(posedge clk) disable iff (rst)
        (fence_q && cnt_q > 1 && !dec) |=> fence_q) else $error("fence released early"); // R2

endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
    import pft_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int NUM_CTRL  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         durable_cfg,
    input  logic                         commit_req,
    input  logic [$clog2(NUM_WARPS)-1:0] commit_warp,
    input  logic [NUM_WARPS-1:0]         cnt_zero,
    input  logic [NUM_CTRL-1:0]          drain_done,
    output logic [NUM_WARPS-1:0]         commit_stall,
    output logic [NUM_CTRL-1:0]          drain_req
);
    localparam int WARP_W = $clog2(NUM_WARPS);

    commit_state_e        state_q;
    logic [NUM_WARPS-1:0] wait_q;
    logic [WARP_W-1:0]    sel_q;
    logic [NUM_CTRL-1:0]  mask_q, mask_left, strobe_q;
    logic                 finish;

    assign mask_left = mask_q & ~drain_done;
    assign finish    = (state_q == CM_DRAIN) && (mask_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CM_IDLE;
            wait_q   <= '0;
            sel_q    <= '0;
            mask_q   <= '0;
            strobe_q <= '0;
        end else begin
            strobe_q <= '0;
            for (int w = 0; w < NUM_WARPS; w++) begin
                if (commit_req && !durable_cfg && commit_warp == WARP_W'(w))
                    wait_q[w] <= 1'b1;
                else if (finish && sel_q == WARP_W'(w))
                    wait_q[w] <= 1'b0;
            end
            case (state_q)
                CM_IDLE: begin
                    if (|wait_q) begin
                        sel_q   <= WARP_W'(first_set(64'(wait_q)));
                        state_q <= CM_FENCE;
                    end
                end
                CM_FENCE: begin
                    if (cnt_zero[sel_q]) begin
                        strobe_q <= '1;
                        mask_q   <= '1;
                        state_q  <= CM_DRAIN;
                    end
                end
                CM_DRAIN: begin
                    mask_q <= mask_left;
                    if (mask_left == '0) state_q <= CM_IDLE;
                end
                default: state_q <= CM_IDLE;
            endcase
        end
    end

    assign commit_stall = wait_q;
    assign drain_req    = strobe_q;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|drain_req) |=> (drain_req == '0)) else $error("strobe too long"); // R5
    AST_DURABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (durable_cfg && state_q == CM_IDLE && wait_q == '0) |=> (drain_req == '0)) else $error("durable strobe"); // R8
    AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == CM_DRAIN && mask_left != '0) |=> commit_stall[sel_q]) else $error("commit released early"); // R6

endmodule

// File: rtl/persist_order_tracker.sv
module persist_order_tracker #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_CTRL  = 8,
    parameter int CNT_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         durable_cfg,
    input  logic                         issue_vld,
    input  logic [$clog2(NUM_WARPS)-1:0] issue_warp,
    input  logic                         ack_vld,
    input  logic [$clog2(NUM_WARPS)-1:0] ack_warp,
    input  logic                         fence_req,
    input  logic [$clog2(NUM_WARPS)-1:0] fence_warp,
    input  logic                         commit_req,
    input  logic [$clog2(NUM_WARPS)-1:0] commit_warp,
    input  logic [NUM_CTRL-1:0]          drain_done,
    output logic [NUM_WARPS-1:0]         warp_stall,
    output logic [NUM_CTRL-1:0]          drain_req
);
    localparam int WARP_W = $clog2(NUM_WARPS);

    logic [NUM_WARPS-1:0] fence_stall, commit_stall, cnt_zero;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        warp_tracker #(.CNT_W(CNT_W)) i_warp_tracker (
            .clk         (clk),
            .rst         (rst),
            .inc         (issue_vld && issue_warp == WARP_W'(w)),
            .dec         (ack_vld && ack_warp == WARP_W'(w)),
            .fence_hit   (fence_req && fence_warp == WARP_W'(w)),
            .fence_stall (fence_stall[w]),
            .cnt_zero    (cnt_zero[w])
        );
    end

    commit_ctrl #(.NUM_WARPS(NUM_WARPS), .NUM_CTRL(NUM_CTRL)) i_commit_ctrl (
        .clk          (clk),
        .rst          (rst),
        .durable_cfg  (durable_cfg),
        .commit_req   (commit_req),
        .commit_warp  (commit_warp),
        .cnt_zero     (cnt_zero),
        .drain_done   (drain_done),
        .commit_stall (commit_stall),
        .drain_req    (drain_req)
    );

    assign warp_stall = fence_stall | commit_stall;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (warp_stall == '0 && drain_req == '0)) else $error("not idle after reset"); // R9
    AST_STROBE_ALL: assert property (@(posedge clk) disable iff (rst)
        (|drain_req) |-> (&drain_req)) else $error("partial strobe"); // R5

endmodule

// File: tb/test_persist_order_tracker.sv
module test_persist_order_tracker;
    localparam int CLK_P     = 10;
    localparam int NUM_WARPS = 8;
    localparam int NUM_CTRL  = 8;
    localparam int CNT_W     = 4;
    localparam int WARP_W    = $clog2(NUM_WARPS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic durable_cfg = 1'b0;
    logic issue_vld = 1'b0, ack_vld = 1'b0, fence_req = 1'b0, commit_req = 1'b0;
    logic [WARP_W-1:0] issue_warp = '0, ack_warp = '0, fence_warp = '0, commit_warp = '0;
    logic [NUM_CTRL-1:0]  drain_done = '0;
    logic [NUM_WARPS-1:0] warp_stall;
    logic [NUM_CTRL-1:0]  drain_req;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    persist_order_tracker #(.NUM_WARPS(NUM_WARPS), .NUM_CTRL(NUM_CTRL), .CNT_W(CNT_W)) i_persist_order_tracker (
        .clk(clk), .rst(rst), .durable_cfg(durable_cfg),
        .issue_vld(issue_vld), .issue_warp(issue_warp),
        .ack_vld(ack_vld), .ack_warp(ack_warp),
        .fence_req(fence_req), .fence_warp(fence_warp),
        .commit_req(commit_req), .commit_warp(commit_warp),
        .drain_done(drain_done), .warp_stall(warp_stall), .drain_req(drain_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input int w);
        issue_vld = 1'b1; issue_warp = WARP_W'(w);
        @(negedge clk); issue_vld = 1'b0;
    endtask

    task automatic ack(input int w);
        ack_vld = 1'b1; ack_warp = WARP_W'(w);
        @(negedge clk); ack_vld = 1'b0;
    endtask

    task automatic fence(input int w);
        fence_req = 1'b1; fence_warp = WARP_W'(w);
        @(negedge clk); fence_req = 1'b0;
    endtask

    task automatic commit(input int w);
        commit_req = 1'b1; commit_warp = WARP_W'(w);
        @(negedge clk); commit_req = 1'b0;
    endtask

    task automatic done(input logic [NUM_CTRL-1:0] bits);
        drain_done = bits;
        @(negedge clk); drain_done = '0;
    endtask

    task automatic wait_strobe(input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (drain_req != '0) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(req, 64'(seen), 64'd1);
        chk(req, 64'(drain_req), 64'(NUM_CTRL'('1)));
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R9 stall after reset", 64'(warp_stall), 64'd0);
        chk("R9 strobe after reset", 64'(drain_req), 64'd0);
    endtask

    task automatic t_fence_idle;
        fence(0);
        chk("R1 fence at zero", 64'(warp_stall[0]), 64'd0);
        @(negedge clk);
        chk("R1 fence at zero later", 64'(warp_stall[0]), 64'd0);
    endtask

    task automatic t_fence_wait;
        for (int i = 0; i < 3; i++) issue(1);
        fence(1);
        chk("R2 fence raises stall", 64'(warp_stall[1]), 64'd1);
        ack(1);
        chk("R2 stall after ack 1", 64'(warp_stall[1]), 64'd1);
        ack(1);
        chk("R2 stall after ack 2", 64'(warp_stall[1]), 64'd1);
        ack(1);
        chk("R2 release on last ack", 64'(warp_stall[1]), 64'd0);
    endtask

    task automatic t_isolation;
        issue(3);
        issue(4);
        fence(3);
        chk("R3 fenced warp stalls", 64'(warp_stall[3]), 64'd1);
        chk("R3 other warps free", 64'(warp_stall & ~(NUM_WARPS'(1) << 3)), 64'd0);
        ack(3);
        chk("R3 fenced warp released", 64'(warp_stall), 64'd0);
        ack(4);
    endtask

    task automatic t_saturate;
        ack(5);
        issue(5);
        fence(5);
        chk("R4 ack at zero ignored", 64'(warp_stall[5]), 64'd1);
        ack(5);
        chk("R4 release after one ack", 64'(warp_stall[5]), 64'd0);
        for (int i = 0; i < 17; i++) issue(6);
        for (int i = 0; i < 14; i++) ack(6);
        fence(6);
        chk("R4 saturated count holds fence", 64'(warp_stall[6]), 64'd1);
        ack(6);
        chk("R4 saturated count drained", 64'(warp_stall[6]), 64'd0);
    endtask

    task automatic t_commit_basic;
        done('1);
        issue(2);
        commit(2);
        chk("R5 commit stalls warp", 64'(warp_stall[2]), 64'd1);
        for (int i = 0; i < 4; i++) begin
            chk("R5 no strobe before ack", 64'(drain_req), 64'd0);
            @(negedge clk);
        end
        ack(2);
        chk("R5 no strobe at ack edge", 64'(drain_req), 64'd0);
        @(negedge clk);
        chk("R5 strobe all controllers", 64'(drain_req), 64'(NUM_CTRL'('1)));
        @(negedge clk);
        chk("R5 strobe one cycle", 64'(drain_req), 64'd0);
        done(8'h80);
        chk("R6 held after one done", 64'(warp_stall[2]), 64'd1);
        done(8'h01);
        done(8'h01);
        chk("R6 repeat done ignored", 64'(warp_stall[2]), 64'd1);
        done(8'h3C);
        chk("R6 held with two missing", 64'(warp_stall[2]), 64'd1);
        done(8'h02);
        chk("R6 held with one missing", 64'(warp_stall[2]), 64'd1);
        done(8'h40);
        chk("R6 release on last done", 64'(warp_stall[2]), 64'd0);
    endtask

    task automatic t_commit_queue;
        commit(4);
        commit(1);
        wait_strobe("R7 first strobe");
        chk("R7 second commit waits", 64'(warp_stall[1]), 64'd1);
        done('1);
        chk("R7 first commit done", 64'(warp_stall[4]), 64'd0);
        chk("R7 second still stalled", 64'(warp_stall[1]), 64'd1);
        wait_strobe("R7 second strobe");
        done('1);
        chk("R7 second commit done", 64'(warp_stall), 64'd0);
    endtask

    task automatic t_durable;
        durable_cfg = 1'b1;
        issue(3);
        commit(3);
        chk("R8 durable no stall", 64'(warp_stall[3]), 64'd0);
        for (int i = 0; i < 5; i++) begin
            chk("R8 durable no strobe", 64'(drain_req), 64'd0);
            @(negedge clk);
        end
        ack(3);
        durable_cfg = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fence_idle();
        t_fence_wait();
        t_isolation();
        t_saturate();
        t_commit_basic();
        t_commit_queue();
        t_durable();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule